// File: doc/BRIEF.md
# Descriptor Ring Pointer Registers

This block is the local-side control point for a DMA engine's command ring. Software programs a ring base address, an end pointer and a control word through a small 32-bit register bus, then posts work by moving the write pointer forward. While the hardware-owned read pointer lags the write pointer, the block asks the downstream sequencer to fetch the descriptor at the read position. The sequencer signals each descriptor it has consumed, and the read pointer steps forward, returning to zero when it reaches the end pointer.

Pointers are kept in entry units rather than bytes or indices. Each 32-byte descriptor occupies two units, so a ring of N descriptors has an end pointer of 2·N, and descriptor k sits at pointer value 2·k. Software cannot load the read pointer directly. Writing one fixed key value to its register returns it to zero, and every other write to that register is discarded. The usual bring-up order is: end pointer, read pointer clear, write pointer cleared to zero, control, then base.

Top module: `cmdring_regblk`

## Requirements
- R1: After reset, every register reads zero and `fetch_req` is low.
- R2: Base (offset 0x14) and control (offset 0x38) read back the full 32-bit value written. End pointer (offset 0x18) reads back the low PTR_W bits of the value written, zero-extended.
- R3: A write to the write pointer (offset 0x1C) is stored only when the value is a multiple of 2 and strictly below the current end pointer. Any other write leaves the write pointer unchanged.
- R4: Writing 0xEE882266 to the read-pointer offset 0x20 sets the read pointer to zero. Any other value written there leaves the read pointer unchanged.
- R5: `fetch_req` is high exactly when the read pointer differs from the write pointer.
- R6: `fetch_addr` equals base + (read pointer / 2) × 32, modulo 2^32.
- R7: A `consume` pulse while `fetch_req` is high advances the read pointer by 2. When the advanced value would reach or pass the end pointer, the read pointer becomes zero instead.
- R8: A `consume` pulse while `fetch_req` is low leaves the read pointer unchanged.
- R9: The status register (offset 0x3C) reads bit 0 = `fetch_req`, with all other bits zero.
- R10: A read returns data on `bus_rdata` on the clock edge after `bus_rd` is sampled, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| fetch_req | output | 1 | Descriptor fetch pending |
| fetch_addr | output | 32 | Byte address of the descriptor to fetch |
| consume | input | 1 | Sequencer has consumed the requested descriptor |

## Verification
The bench sweeps every write-pointer value from zero to past the end pointer. A filter that checks only one of parity or range lets either odd values or the value equal to the end pointer into the ring, and the readback then shows it. It walks the ring through several wraps with varying batch sizes and checks each fetch address on the way. An off-by-one in the wrap test would either fetch one slot past the ring or skip slot zero. It also pulses `consume` on an idle ring and writes non-key values to the read pointer. A design that did not gate either path would move the read pointer and raise a spurious fetch.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;

  localparam int BUS_AW = 8;
  localparam int BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFS_BASE = 8'h14;
  localparam logic [BUS_AW-1:0] OFS_END  = 8'h18;
  localparam logic [BUS_AW-1:0] OFS_WPTR = 8'h1C;
  localparam logic [BUS_AW-1:0] OFS_RPTR = 8'h20;
  localparam logic [BUS_AW-1:0] OFS_CTRL = 8'h38;
  localparam logic [BUS_AW-1:0] OFS_STAT = 8'h3C;

  localparam logic [BUS_DW-1:0] RPTR_CLEAR_KEY = 32'hEE88_2266;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_BASE,
    SEL_END,
    SEL_WPTR,
    SEL_RPTR,
    SEL_CTRL,
    SEL_STAT
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [BUS_AW-1:0] ofs);
    reg_sel_e s;
    case (ofs)
      OFS_BASE: s = SEL_BASE;
      OFS_END:  s = SEL_END;
      OFS_WPTR: s = SEL_WPTR;
      OFS_RPTR: s = SEL_RPTR;
      OFS_CTRL: s = SEL_CTRL;
      OFS_STAT: s = SEL_STAT;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cmdring_regs.sv
module cmdring_regs
  import cmdring_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic [BUS_DW-1:0] base_o,
  output logic [PTR_W-1:0]  end_o,
  output logic              wptr_wr_o,
  output logic              rptr_wr_o,
  input  logic [PTR_W-1:0]  wptr_i,
  input  logic [PTR_W-1:0]  rptr_i,
  input  logic              pending_i
);

  reg_sel_e sel;
  logic [BUS_DW-1:0] base_q, ctrl_q, rdata_q, rdata_d;
  logic [PTR_W-1:0]  end_q;
  logic base_en, end_en, ctrl_en;

  assign sel = decode_ofs(bus_addr);

  always_comb begin
    base_en   = bus_wr && (sel == SEL_BASE);
    end_en    = bus_wr && (sel == SEL_END);
    ctrl_en   = bus_wr && (sel == SEL_CTRL);
    wptr_wr_o = bus_wr && (sel == SEL_WPTR);
    rptr_wr_o = bus_wr && (sel == SEL_RPTR);
  end

  always_comb begin
    case (sel)
      SEL_BASE: rdata_d = base_q;
      SEL_END:  rdata_d = BUS_DW'(end_q);
      SEL_WPTR: rdata_d = BUS_DW'(wptr_i);
      SEL_RPTR: rdata_d = BUS_DW'(rptr_i);
      SEL_CTRL: rdata_d = ctrl_q;
      SEL_STAT: rdata_d = {{(BUS_DW-1){1'b0}}, pending_i};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      end_q   <= '0;
      ctrl_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (base_en) base_q  <= bus_wdata;
      if (end_en)  end_q   <= bus_wdata[PTR_W-1:0];
      if (ctrl_en) ctrl_q  <= bus_wdata;
      if (bus_rd)  rdata_q <= rdata_d;
    end
  end

  assign base_o    = base_q;
  assign end_o     = end_q;
  assign bus_rdata = rdata_q;

  // R10: read data only moves on a sampled read strobe
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R2: base changes only through a write to its offset
  a_r2_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFS_BASE) |=> $stable(base_o));

endmodule

// File: rtl/cmdring_ptrs.sv
module cmdring_ptrs
  import cmdring_pkg::*;
#(
  parameter int PTR_W        = 16,
  parameter int ENTRY_UNITS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wptr_wr,
  input  logic              rptr_wr,
  input  logic [BUS_DW-1:0] wdata,
  input  logic [PTR_W-1:0]  end_i,
  input  logic              consume,
  output logic [PTR_W-1:0]  wptr_o,
  output logic [PTR_W-1:0]  rptr_o,
  output logic              pending_o
);

  localparam logic [BUS_DW-1:0] UNIT_MASK = BUS_DW'(ENTRY_UNITS - 1);
  localparam logic [PTR_W:0]    STEP      = (PTR_W+1)'(ENTRY_UNITS);

  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic             wptr_en, rptr_en;
  logic             wr_aligned, wr_in_ring, rptr_clear, take;
  logic [PTR_W:0]   rptr_step;
  logic [PTR_W-1:0] rptr_adv;

  always_comb begin
    wr_aligned = (wdata & UNIT_MASK) == '0;
    wr_in_ring = wdata < BUS_DW'(end_i);
    wptr_en    = wptr_wr && wr_aligned && wr_in_ring;
    wptr_d     = wdata[PTR_W-1:0];
  end

  always_comb begin
    rptr_clear = rptr_wr && (wdata == RPTR_CLEAR_KEY);
    take       = consume && pending_o;
    rptr_step  = {1'b0, rptr_q} + STEP;
    rptr_adv   = (rptr_step >= {1'b0, end_i}) ? '0 : rptr_step[PTR_W-1:0];
    rptr_en    = rptr_clear || take;
    rptr_d     = rptr_clear ? '0 : rptr_adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wptr_en) wptr_q <= wptr_d;
      if (rptr_en) rptr_q <= rptr_d;
    end
  end

  assign wptr_o    = wptr_q;
  assign rptr_o    = rptr_q;
  assign pending_o = (rptr_q != wptr_q);

  // R3: write pointer moves only on a write to its offset
  a_r3_wptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wptr_wr |=> $stable(wptr_o));

  // R3: stored write pointer is always unit-aligned
  a_r3_wptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (BUS_DW'(wptr_o) & UNIT_MASK) == '0);

  // R4: key write returns the read pointer to zero
  a_r4_key_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rptr_wr && wdata == RPTR_CLEAR_KEY) |=> (rptr_o == '0));

  // R8: no consume-with-request and no key write means the read pointer holds
  a_r8_rptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(consume && pending_o) && !(rptr_wr && wdata == RPTR_CLEAR_KEY)) |=> $stable(rptr_o));

  // R7: the read pointer stays unit-aligned
  a_r7_rptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (BUS_DW'(rptr_o) & UNIT_MASK) == '0);

endmodule

// File: rtl/cmdring_addr.sv
module cmdring_addr
  import cmdring_pkg::*;
#(
  parameter int PTR_W       = 16,
  parameter int ENTRY_UNITS = 2,
  parameter int DESC_BYTES  = 32
) (
  input  logic [BUS_DW-1:0] base_i,
  input  logic [PTR_W-1:0]  rptr_i,
  output logic [BUS_DW-1:0] addr_o
);

  localparam int UNIT_LG = $clog2(ENTRY_UNITS);
  localparam int DESC_LG = $clog2(DESC_BYTES);

  logic [BUS_DW-1:0] slot;

  always_comb begin
    slot   = BUS_DW'(rptr_i) >> UNIT_LG;
    addr_o = base_i + (slot << DESC_LG);
  end

endmodule

// File: rtl/cmdring_regblk.sv
module cmdring_regblk
  import cmdring_pkg::*;
#(
  parameter int PTR_W       = 16,
  parameter int ENTRY_UNITS = 2,
  parameter int DESC_BYTES  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        fetch_req,
  output logic [31:0] fetch_addr,
  input  logic        consume
);

  logic [BUS_DW-1:0] base_w;
  logic [PTR_W-1:0]  end_w, wptr_w, rptr_w;
  logic              wptr_wr_w, rptr_wr_w, pending_w;

  cmdring_regs #(.PTR_W(PTR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .base_o    (base_w),
    .end_o     (end_w),
    .wptr_wr_o (wptr_wr_w),
    .rptr_wr_o (rptr_wr_w),
    .wptr_i    (wptr_w),
    .rptr_i    (rptr_w),
    .pending_i (pending_w)
  );

  cmdring_ptrs #(.PTR_W(PTR_W), .ENTRY_UNITS(ENTRY_UNITS)) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wptr_wr   (wptr_wr_w),
    .rptr_wr   (rptr_wr_w),
    .wdata     (bus_wdata),
    .end_i     (end_w),
    .consume   (consume),
    .wptr_o    (wptr_w),
    .rptr_o    (rptr_w),
    .pending_o (pending_w)
  );

  cmdring_addr #(.PTR_W(PTR_W), .ENTRY_UNITS(ENTRY_UNITS), .DESC_BYTES(DESC_BYTES)) u_addr (
    .base_i (base_w),
    .rptr_i (rptr_w),
    .addr_o (fetch_addr)
  );

  assign fetch_req = pending_w;

  // R5: with no request pending, the fetch address holds unless base is written
  a_r5_idle_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_req && !bus_wr) |=> $stable(fetch_addr));

endmodule

// File: tb/sim_cmdring_regblk.sv
module sim_cmdring_regblk;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd, consume;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        fetch_req;
  logic [31:0] fetch_addr;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  localparam int RING_N = 4;
  localparam logic [31:0] END_V  = 32'(2 * RING_N);
  localparam logic [31:0] BASE_V = 32'h1000_0F00;

  always #5 clk = ~clk;

  cmdring_regblk u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .consume(consume)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic pulse_consume();
    @(negedge clk);
    consume = 1'b1;
    @(negedge clk);
    consume = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vecs++; errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int exp_wp, wp_idx, rp_idx;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; consume = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every register and the request line
    chk("R1 fetch_req", 32'(fetch_req), 0);
    rd(8'h14, v); chk("R1 base", v, 0);
    rd(8'h18, v); chk("R1 end", v, 0);
    rd(8'h1C, v); chk("R1 wptr", v, 0);
    rd(8'h20, v); chk("R1 rptr", v, 0);
    rd(8'h38, v); chk("R1 ctrl", v, 0);
    rd(8'h3C, v); chk("R1 status", v, 0);

    // R10: unmapped offsets read zero
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, v); chk("R10 unmapped 0x24", v, 0);
    rd(8'h00, v); chk("R10 unmapped 0x00", v, 0);

    // R2: end pointer keeps only PTR_W bits
    wr(8'h18, 32'hABCD_0008);
    rd(8'h18, v); chk("R2 end masked", v, 32'h0000_0008);

    // bring-up sequence
    wr(8'h18, END_V);
    wr(8'h20, 32'hEE88_2266);
    wr(8'h1C, 0);
    wr(8'h38, 32'h5A5A_00C3);
    wr(8'h14, BASE_V);
    rd(8'h38, v); chk("R2 ctrl", v, 32'h5A5A_00C3);
    rd(8'h14, v); chk("R2 base", v, BASE_V);
    chk("R6 idle addr", fetch_addr, BASE_V);

    // R3 sweep: every write-pointer value from 0 past the end pointer
    exp_wp = 0;
    for (int k = 0; k < 12; k++) begin
      wr(8'h1C, 32'(k));
      if ((k % 2) == 0 && k < int'(END_V)) exp_wp = k;
      rd(8'h1C, v); chk($sformatf("R3 wptr write %0d", k), v, 32'(exp_wp));
      chk($sformatf("R5 req after wptr %0d", k), 32'(fetch_req), 32'(exp_wp != 0));
      rd(8'h3C, v); chk($sformatf("R9 status after wptr %0d", k), v, 32'(exp_wp != 0));
    end
    wr(8'h1C, 0);
    chk("R5 req cleared", 32'(fetch_req), 0);

    // R7/R6 ring walk across several wraps
    wp_idx = 0; rp_idx = 0;
    for (int s = 0; s < 9; s++) begin
      wp_idx = (wp_idx + (s % 3) + 1) % RING_N;
      wr(8'h1C, 32'(2 * wp_idx));
      while (rp_idx != wp_idx) begin
        chk("R5 req while behind", 32'(fetch_req), 1);
        chk($sformatf("R6 addr slot %0d", rp_idx), fetch_addr, BASE_V + 32'(rp_idx * 32));
        pulse_consume();
        rp_idx = (rp_idx + 1) % RING_N;
      end
      chk("R5 req drained", 32'(fetch_req), 0);
      rd(8'h20, v); chk($sformatf("R7 rptr step %0d", s), v, 32'(2 * rp_idx));
    end

    // R8: consume on an idle ring
    pulse_consume();
    rd(8'h20, v); chk("R8 rptr idle consume", v, 32'(2 * rp_idx));
    chk("R8 req idle consume", 32'(fetch_req), 0);

    // R4: non-key writes ignored, key write clears
    wp_idx = (rp_idx + 2) % RING_N;
    wr(8'h1C, 32'(2 * wp_idx));
    pulse_consume();
    rp_idx = (rp_idx + 1) % RING_N;
    wr(8'h20, 32'h0000_0000);
    rd(8'h20, v); chk("R4 zero write ignored", v, 32'(2 * rp_idx));
    wr(8'h20, 32'hEE88_2267);
    rd(8'h20, v); chk("R4 near-key ignored", v, 32'(2 * rp_idx));
    wr(8'h20, 32'hEE88_2266);
    rd(8'h20, v); chk("R4 key clears", v, 0);
    chk("R5 req after clear", 32'(fetch_req), 32'(wp_idx != 0));
    chk("R6 addr after clear", fetch_addr, BASE_V);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule